// File: doc/BRIEF.md
# Processor-to-Cache Request Crossbar

This block carries request packets from a set of processor cores to a set of shared targets: several cache banks, an I/O bridge and a floating-point unit. Every core has its own input bus. It presents a packet, a one-hot target select and a valid bit. The crossbar queues the packet at the selected target. Each target owns a queue and an arbiter. The queue releases packets in the order they arrived, at most one per cycle, and the payload bits are never changed.

When several cores aim at the same target in one cycle, a rotating-priority arbiter admits one of them. The others keep their requests up and are admitted on later cycles. A core may hold only a bounded number of entries in any one queue. Every target except the last one (the floating-point unit) has a stall input that freezes its queue. After a packet leaves its queue, the crossbar sends the originating core a one-cycle grant pulse on the lane of that target. A core that sends to two targets can therefore tell the two grants apart.

The packet width is the sum of address, data and control field widths, 124 bits by default. The defaults are 8 cores, 5 targets, a 16-entry queue and a limit of 2 entries per core.

Top module: `xbar_fwd`

## Requirements
- R1: After a synchronous reset, every queue is empty. `dst_vld`, `src_gnt` and `src_rdy` are all zero until a request arrives.
- R2: `req_dst` is one-hot, and bit d selects target d. A valid request with no bit set or with several bits set is never accepted, never delivered and never granted.
- R3: A request is accepted at a rising edge where `req_vld[s]` and `src_rdy[s]` are both high. `src_rdy` is combinational and rises only for a request that is one-hot and admissible at that target. The source must hold its request until it is accepted.
- R4: Each target delivers packets in acceptance order, with the payload bit-identical to what the source presented.
- R5: A target admits at most one packet per cycle. Among simultaneous eligible requesters, the search starts at a pointer that moves to the index after the source last admitted. The pointer resets to source 0.
- R6: A source that already holds CAP entries in a target's queue is not ready at that target, even if the queue has space. It becomes eligible again when one of its entries leaves the queue.
- R7: A queue holding DEPTH entries admits nothing.
- R8: While `dst_stall[d]` is high, target d does not dispatch: `dst_vld[d]` is low in the following cycle. The last target has no stall input and always drains.
- R9: A packet accepted at edge k into an empty, unstalled queue appears on `dst_vld`/`dst_pkt` after edge k+1. Back-to-back entries leave on consecutive cycles.
- R10: In the cycle after a packet is shown on `dst_vld[d]`, exactly one pulse appears on `src_gnt[s][d]`, where s is that packet's source. No grant appears at any other time.
- R11: Requests to different targets in the same cycle are all accepted, delivered and granted in parallel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | N_SRC | Request valid per source |
| req_dst | input | N_SRC x N_DST | One-hot target select per source |
| req_pkt | input | N_SRC x PKT_W | Request packet per source |
| src_rdy | output | N_SRC | Request accepted at this edge (combinational) |
| src_gnt | output | N_SRC x N_DST | Dispatch grant pulse, per source and target |
| dst_stall | input | N_DST-1 | Stall per target, except the last |
| dst_vld | output | N_DST | Packet dispatched on this target |
| dst_pkt | output | N_DST x PKT_W | Dispatched packet per target |

## Verification
The bench builds the crossbar with 4 sources, 3 targets, a 16-bit packet, a 4-entry queue and a per-source limit of 2. With these values, four sources can fill one queue, so the full-queue refusal in R7 is reachable separately from the per-source limit in R6. A source that keeps its request up can also show that the rotating pointer moves past it rather than serving it again. The third target stands in for the unstallable port, so stalling every other target isolates the behaviour of R8.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Increment with wrap at n (0..n-1)
  function automatic int wrap_inc(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xbar_rr_pick.sv
module xbar_rr_pick #(
  parameter int N = 8,
  localparam int IW = xbar_pkg::idx_w(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  elig,
  output logic          win_vld,
  output logic [IW-1:0] win_idx
);
  logic [IW-1:0] ptr;

  always_comb begin
    win_vld = 1'b0;
    win_idx = ptr;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!win_vld && elig[idx]) begin
        win_vld = 1'b1;
        win_idx = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (win_vld)
      ptr <= IW'(xbar_pkg::wrap_inc(int'(win_idx), N));
  end

  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> elig[win_idx]); // R3
  AST_PTR_MOVES: assert property (@(posedge clk) disable iff (rst)
    win_vld |=> ptr != $past(win_idx) || N == 1); // R5
endmodule

// File: rtl/xbar_dst_lane.sv
module xbar_dst_lane #(
  parameter int N_SRC = 8,
  parameter int PKT_W = 124,
  parameter int DEPTH = 16,
  parameter int CAP   = 2,
  localparam int IW = xbar_pkg::idx_w(N_SRC),
  localparam int AW = xbar_pkg::idx_w(DEPTH),
  localparam int FW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(CAP + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_SRC-1:0]             hit,
  input  logic [N_SRC-1:0][PKT_W-1:0]  pkt_in,
  input  logic                         stall,
  output logic [N_SRC-1:0]             take,
  output logic                         out_vld,
  output logic [PKT_W-1:0]             out_pkt,
  output logic [N_SRC-1:0]             gnt
);
  logic [PKT_W-1:0] mem [DEPTH];
  logic [IW-1:0]    tag [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [FW-1:0]    fill;
  logic [CW-1:0]    held [N_SRC];
  logic [N_SRC-1:0] elig;
  logic             full, push, pop;
  logic [IW-1:0]    win_idx;
  logic [IW-1:0]    out_src;

  assign full = (fill == FW'(DEPTH));
  assign pop  = (fill != '0) && !stall;

  always_comb begin
    for (int s = 0; s < N_SRC; s++)
      elig[s] = hit[s] && (held[s] < CW'(CAP)) && !full;
  end

  xbar_rr_pick #(.N(N_SRC)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .elig    (elig),
    .win_vld (push),
    .win_idx (win_idx)
  );

  always_comb begin
    take = '0;
    if (push) take[win_idx] = 1'b1;
  end

  // Storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr] <= pkt_in[win_idx];
      tag[wr_ptr] <= win_idx;
    end
    if (pop) begin
      out_pkt <= mem[rd_ptr];
      out_src <= tag[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
      out_vld <= 1'b0;
      gnt     <= '0;
      for (int s = 0; s < N_SRC; s++) held[s] <= '0;
    end else begin
      if (push) wr_ptr <= AW'(xbar_pkg::wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(xbar_pkg::wrap_inc(int'(rd_ptr), DEPTH));
      fill <= fill + FW'(push) - FW'(pop);
      for (int s = 0; s < N_SRC; s++) begin
        held[s] <= held[s] + CW'(push && (win_idx == IW'(s)))
                           - CW'(pop && (tag[rd_ptr] == IW'(s)));
      end
      out_vld <= pop;
      gnt <= '0;
      if (out_vld) gnt[out_src] <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(DEPTH)); // R7
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (rst)
    full |-> take == '0); // R7
  AST_ONE_ADMIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take)); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    stall |=> !out_vld); // R8
  AST_GNT_AFTER_SEND: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> $onehot(gnt)); // R10
  AST_GNT_ONLY_AFTER_SEND: assert property (@(posedge clk) disable iff (rst)
    !out_vld |=> gnt == '0); // R10

  for (genvar s = 0; s < N_SRC; s++) begin : g_cap
    AST_SRC_CAP: assert property (@(posedge clk) disable iff (rst)
      held[s] <= CW'(CAP)); // R6
  end
endmodule

// File: rtl/xbar_fwd.sv
module xbar_fwd #(
  parameter int N_SRC  = 8,
  parameter int N_DST  = 5,
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int CTRL_W = 20,
  parameter int DEPTH  = 16,
  parameter int CAP    = 2,
  localparam int PKT_W = ADDR_W + DATA_W + CTRL_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_SRC-1:0]            req_vld,
  input  logic [N_SRC-1:0][N_DST-1:0] req_dst,
  input  logic [N_SRC-1:0][PKT_W-1:0] req_pkt,
  output logic [N_SRC-1:0]            src_rdy,
  output logic [N_SRC-1:0][N_DST-1:0] src_gnt,
  input  logic [N_DST-2:0]            dst_stall,
  output logic [N_DST-1:0]            dst_vld,
  output logic [N_DST-1:0][PKT_W-1:0] dst_pkt
);
  logic [N_DST-1:0][N_SRC-1:0] lane_hit;
  logic [N_DST-1:0][N_SRC-1:0] lane_take;
  logic [N_DST-1:0][N_SRC-1:0] lane_gnt;
  logic [N_DST-1:0]            lane_stall;

  always_comb begin
    for (int d = 0; d < N_DST; d++)
      for (int s = 0; s < N_SRC; s++)
        lane_hit[d][s] = req_vld[s] && $onehot(req_dst[s]) && req_dst[s][d];
  end

  for (genvar d = 0; d < N_DST; d++) begin : g_lane
    if (d == N_DST - 1) begin : g_nostall
      assign lane_stall[d] = 1'b0;
    end else begin : g_stall
      assign lane_stall[d] = dst_stall[d];
    end

    xbar_dst_lane #(
      .N_SRC (N_SRC),
      .PKT_W (PKT_W),
      .DEPTH (DEPTH),
      .CAP   (CAP)
    ) u_lane (
      .clk     (clk),
      .rst     (rst),
      .hit     (lane_hit[d]),
      .pkt_in  (req_pkt),
      .stall   (lane_stall[d]),
      .take    (lane_take[d]),
      .out_vld (dst_vld[d]),
      .out_pkt (dst_pkt[d]),
      .gnt     (lane_gnt[d])
    );
  end

  always_comb begin
    src_rdy = '0;
    for (int s = 0; s < N_SRC; s++)
      for (int d = 0; d < N_DST; d++) begin
        src_rdy[s]    = src_rdy[s] | lane_take[d][s];
        src_gnt[s][d] = lane_gnt[d][s];
      end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src_chk
    AST_BAD_DST_IGNORED: assert property (@(posedge clk) disable iff (rst)
      !$onehot(req_dst[s]) |-> !src_rdy[s]); // R2
    AST_RDY_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
      src_rdy[s] |-> req_vld[s]); // R3
  end
endmodule

// File: tb/xbar_fwd_test.sv
module xbar_fwd_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int ND = 3;
  localparam int PW = 16;

  logic                   clk = 1'b0;
  logic                   rst;
  logic [NS-1:0]          vld;
  logic [NS-1:0][ND-1:0]  dst;
  logic [NS-1:0][PW-1:0]  pkt;
  logic [NS-1:0]          rdy;
  logic [NS-1:0][ND-1:0]  gnt;
  logic [ND-2:0]          stall;
  logic [ND-1:0]          ovld;
  logic [ND-1:0][PW-1:0]  opkt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xbar_fwd #(
    .N_SRC(NS), .N_DST(ND), .ADDR_W(8), .DATA_W(4), .CTRL_W(4),
    .DEPTH(4), .CAP(2)
  ) uut (
    .clk(clk), .rst(rst), .req_vld(vld), .req_dst(dst), .req_pkt(pkt),
    .src_rdy(rdy), .src_gnt(gnt), .dst_stall(stall),
    .dst_vld(ovld), .dst_pkt(opkt)
  );

  // {src[21:20], dst[19:17], payload[16:1], ok[0]}
  localparam logic [21:0] VEC [0:7] = '{
    {2'd0, 3'b001, 16'h1234, 1'b1},
    {2'd1, 3'b010, 16'h5678, 1'b1},
    {2'd2, 3'b100, 16'h9ABC, 1'b1},
    {2'd3, 3'b001, 16'hDEF0, 1'b1},
    {2'd1, 3'b000, 16'h1111, 1'b0},
    {2'd2, 3'b011, 16'h2222, 1'b0},
    {2'd0, 3'b110, 16'h3333, 1'b0},
    {2'd3, 3'b100, 16'h4444, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; vld = '0; dst = '0; pkt = '0; stall = '0;
    step(); step();
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk("R1 rdy", 32'(rdy), 0);
    chk("R1 vld", 32'(ovld), 0);
    chk("R1 gnt", 32'(gnt), 0);

    // Vector table: single requests, R2 R3 R9 R10 R4
    for (int i = 0; i < 8; i++) begin
      logic [1:0]  s;
      logic [2:0]  d;
      logic [15:0] p;
      logic        ok;
      {s, d, p, ok} = VEC[i];
      vld[s] = 1'b1; dst[s] = d; pkt[s] = p;
      #1;
      chk("R3 rdy", 32'(rdy), ok ? (32'd1 << s) : 0);
      step();
      vld = '0;
      step();
      chk("R9 vld", 32'(ovld), ok ? 32'(d) : 0);
      if (ok) begin
        for (int k = 0; k < ND; k++)
          if (d[k]) chk("R4 payload", 32'(opkt[k]), 32'(p));
      end
      step();
      chk("R10 gnt", 32'(gnt), ok ? (32'd1 << (s * ND + (d[2] ? 2 : d[1] ? 1 : 0))) : 0);
      chk("R2 R9 vld idle", 32'(ovld), 0);
    end

    // R5 rotating priority, R7 full queue, R8 stall
    do_reset();
    stall[0] = 1'b1;
    for (int s = 0; s < NS; s++) begin
      vld[s] = 1'b1; dst[s] = 3'b001; pkt[s] = 16'hA000 + 16'(s);
    end
    for (int i = 0; i < NS; i++) begin
      #1;
      chk("R5 rr order", 32'(rdy), 32'd1 << i);
      step();
      chk("R8 stalled", 32'(ovld[0]), 0);
    end
    #1;
    chk("R7 full refuses", 32'(rdy), 0);
    vld = '0; stall = '0;
    for (int i = 0; i < NS; i++) begin
      step();
      chk("R9 drain vld", 32'(ovld[0]), 1);
      chk("R4 drain order", 32'(opkt[0]), 32'hA000 + 32'(i));
      if (i > 0) chk("R10 drain gnt", 32'(gnt), 32'd1 << ((i - 1) * ND));
    end
    step();
    chk("R10 last gnt", 32'(gnt), 32'd1 << (3 * ND));
    chk("R9 empty", 32'(ovld), 0);

    // R6 per-source limit
    do_reset();
    stall[1] = 1'b1;
    vld[1] = 1'b1; dst[1] = 3'b010; pkt[1] = 16'hB001;
    #1; chk("R6 first", 32'(rdy), 32'b0010);
    step();
    pkt[1] = 16'hB002;
    #1; chk("R6 second", 32'(rdy), 32'b0010);
    step();
    pkt[1] = 16'hB003;
    vld[2] = 1'b1; dst[2] = 3'b010; pkt[2] = 16'hC002;
    #1; chk("R6 cap blocks src1", 32'(rdy), 32'b0100);
    step();
    vld[2] = 1'b0;
    #1; chk("R6 cap holds", 32'(rdy), 0);
    vld = '0; stall = '0;
    step(); chk("R4 cap drain 0", 32'(opkt[1]), 32'hB001);
    step(); chk("R4 cap drain 1", 32'(opkt[1]), 32'hB002);
    step(); chk("R4 cap drain 2", 32'(opkt[1]), 32'hC002);

    // R8 last target ignores stall
    do_reset();
    stall = '1;
    vld[3] = 1'b1; dst[3] = 3'b100; pkt[3] = 16'hD00D;
    vld[0] = 1'b1; dst[0] = 3'b001; pkt[0] = 16'h0BAD;
    #1; chk("R8 both accepted", 32'(rdy), 32'b1001);
    step();
    vld = '0;
    step();
    chk("R8 only last sends", 32'(ovld), 32'b100);
    chk("R8 last payload", 32'(opkt[2]), 32'hD00D);
    step();
    chk("R8 last gnt", 32'(gnt), 32'd1 << (3 * ND + 2));

    // R11 parallel targets
    do_reset();
    for (int s = 0; s < 3; s++) begin
      vld[s] = 1'b1; dst[s] = 3'(1 << s); pkt[s] = 16'hE000 + 16'(s);
    end
    #1; chk("R11 all rdy", 32'(rdy), 32'b0111);
    step();
    vld = '0;
    step();
    chk("R11 all send", 32'(ovld), 32'b111);
    chk("R11 pkt2", 32'(opkt[2]), 32'hE002);
    step();
    chk("R11 all gnt", 32'(gnt), 32'h111);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule